// File: doc/BRIEF.md
# Power-On Self-Test and Memory Checksum Sequencer

This block runs the start-up sequence once reset is released. It holds an active-low failure output low while an external self-test engine works. It waits for that engine's done strobe and its pass/fail result. On a pass it releases the failure output. It then fetches a fixed number of words from the bottom of memory over a one-outstanding request/valid read port and adds them together.

If the wrapped 32-bit total is zero, the block gives a one-cycle `init_done` pulse and initialization carries on. A failed self-test, or a nonzero total, drives the failure output low again. It stays low until the next reset. The failure output is active-low (0 = failure, 1 = healthy) so it can feed an open-drain pad.

The states are:

- `BS_SELFTEST`: the reset state. It waits for `st_done`.
- `BS_REQ`: issues one read.
- `BS_WAIT`: waits for `mem_rvalid`.
- `BS_CHECK`: holds the verdict for one cycle.
- `BS_PASS`: the idle state after success.
- `BS_FAILED`: the sticky failure state.

The transitions are:

- SELFTEST to REQ on done with pass.
- SELFTEST to FAILED on done without pass.
- REQ to WAIT always.
- WAIT to REQ on valid for a word that is not the last.
- WAIT to CHECK on valid for the last word.
- CHECK to PASS on a zero total.
- CHECK to FAILED on a nonzero total.
- PASS and FAILED stay where they are until reset.

Top module: `boot_selftest_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `fail_n` is 0, `mem_req` is 0 and `init_done` is 0.
- R2: Until `st_done` is seen high, `fail_n` stays 0 and no `mem_req` is issued.
- R3: When `st_done`=1 with `st_pass`=1 is sampled, the next cycle shows `fail_n`=1 and `mem_req`=1 with `mem_addr`=0.
- R4: When `st_done`=1 with `st_pass`=0 is sampled, `fail_n` becomes 0 from the next cycle and stays 0 until reset; no `mem_req` is ever issued.
- R5: The block makes exactly 8 reads at byte addresses 0, 4, 8, …, 28 in ascending order. Each `mem_req` lasts one cycle. No new request is issued while waiting for `mem_rvalid`. The next request appears in the cycle after `mem_rvalid` is accepted.
- R6: A `mem_rvalid` that arrives while no read is outstanding (during self-test, in the request cycle, or after the verdict) has no effect on the total.
- R7: If the sum of the 8 words modulo 2^32 is zero, then in the cycle after the last accepted `mem_rvalid` the block gives `init_done`=1 for exactly one cycle, and `fail_n` stays 1 from then on.
- R8: If that sum is nonzero, `fail_n` is 0 in the cycle after the last accepted `mem_rvalid` and stays 0 until reset; `init_done` is never raised.
- R9: Asserting `rst_n` low at any point (including mid-read) forces `fail_n`=0 and `mem_req`=0 at once. The next release restarts from the self-test phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_done | input | 1 | Self-test finished (level, sampled in self-test phase) |
| st_pass | input | 1 | Self-test result, 1 = pass, qualified by st_done |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W (32) | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W (32) | Read data |
| fail_n | output | 1 | Active-low failure indicator |
| init_done | output | 1 | One-cycle pulse on a passing checksum |

## Verification
The bench targets the following corner cases:

- **Carry wrap-around.** Sets such as 0xFFFFFFFF + 1 must pass. A design that kept carries would flag a failure.
- **Stray valid strobes.** Valid pulses arrive during self-test, in the request cycle and after the verdict. A design that accepted them would corrupt the total and fail a zero-sum set.
- **Failed self-test.** A design that still read memory would show a request.
- **Reset in mid-read.** A design with stale counters would read from the wrong address on restart.

Random memory contents are fed both as forced zero-sum sets and as random sets, with random valid latency. This catches a lost word, an address stepped wrongly, or a verdict that is late by a cycle.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
    typedef enum logic [2:0] {
        BS_SELFTEST = 3'd0,
        BS_REQ      = 3'd1,
        BS_WAIT     = 3'd2,
        BS_CHECK    = 3'd3,
        BS_PASS     = 3'd4,
        BS_FAILED   = 3'd5
    } boot_state_e;
endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_done,
    input  logic st_pass,
    input  logic rvalid,
    input  logic last_word,
    input  logic sum_zero,
    output logic rd_req,
    output logic beat_ok,
    output logic fail_n,
    output logic init_done
);
    boot_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_SELFTEST;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_SELFTEST: if (st_done) state_d = st_pass ? BS_REQ : BS_FAILED;
            BS_REQ:      state_d = BS_WAIT;
            BS_WAIT:     if (rvalid) state_d = last_word ? BS_CHECK : BS_REQ;
            BS_CHECK:    state_d = sum_zero ? BS_PASS : BS_FAILED;
            BS_PASS:     state_d = BS_PASS;
            BS_FAILED:   state_d = BS_FAILED;
            default:     state_d = BS_FAILED;
        endcase
    end

    // outputs
    always_comb begin
        rd_req    = 1'b0;
        beat_ok   = 1'b0;
        fail_n    = 1'b1;
        init_done = 1'b0;
        unique case (state_q)
            BS_SELFTEST: fail_n = 1'b0;
            BS_REQ:      rd_req = 1'b1;
            BS_WAIT:     beat_ok = rvalid;
            BS_CHECK: begin
                init_done = sum_zero;
                fail_n    = sum_zero;
            end
            BS_PASS:     fail_n = 1'b1;
            BS_FAILED:   fail_n = 1'b0;
            default:     fail_n = 1'b0;
        endcase
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R5
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_FAILED) |=> (state_q == BS_FAILED && !fail_n)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (!init_done && fail_n)); // R7
    AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_PASS) |=> (fail_n && !rd_req)); // R7
endmodule

// File: rtl/boot_word_ctr.sv
module boot_word_ctr #(
    parameter int NWORDS     = 8,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic              last_word,
    output logic [ADDR_W-1:0] addr
);
    localparam int CNT_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int SHIFT = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idx_q <= '0;
        else if (advance && !last_word) idx_q <= idx_q + 1'b1;
    end

    assign last_word = (idx_q == CNT_W'(NWORDS - 1));

    generate
        if ((1 << SHIFT) == WORD_BYTES) begin : g_shift
            assign addr = ADDR_W'(idx_q) << SHIFT;
        end else begin : g_mul
            assign addr = ADDR_W'(idx_q) * ADDR_W'(WORD_BYTES);
        end
    endgenerate

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(idx_q) < NWORDS)); // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !last_word) |=> (addr == $past(addr) + ADDR_W'(WORD_BYTES))); // R5
endmodule

// File: rtl/boot_sum_accum.sv
module boot_sum_accum #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [DATA_W-1:0] word,
    output logic              sum_zero
);
    logic [DATA_W-1:0] sum_q;

    // carries out of the top bit are dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum_q <= '0;
        else if (add_en) sum_q <= sum_q + word;
    end

    assign sum_zero = (sum_q == '0);

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(sum_q)); // R6
endmodule

// File: rtl/boot_selftest_seq.sv
module boot_selftest_seq #(
    parameter int NWORDS     = 8,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_done,
    input  logic              st_pass,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fail_n,
    output logic              init_done
);
    logic last_word, sum_zero, beat_ok;

    boot_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_done   (st_done),
        .st_pass   (st_pass),
        .rvalid    (mem_rvalid),
        .last_word (last_word),
        .sum_zero  (sum_zero),
        .rd_req    (mem_req),
        .beat_ok   (beat_ok),
        .fail_n    (fail_n),
        .init_done (init_done)
    );

    boot_word_ctr #(
        .NWORDS     (NWORDS),
        .WORD_BYTES (WORD_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (beat_ok),
        .last_word (last_word),
        .addr      (mem_addr)
    );

    boot_sum_accum #(
        .DATA_W (DATA_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (beat_ok),
        .word     (mem_rdata),
        .sum_zero (sum_zero)
    );

    AST_REQ_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fail_n); // R3
    AST_DONE_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (fail_n && !mem_req)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!fail_n && !mem_req && !init_done)); // R1
endmodule

// File: tb/tb_boot_selftest_seq.sv
module tb_boot_selftest_seq;
    logic        clk = 0;
    logic        rst_n;
    logic        st_done, st_pass;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        fail_n, init_done;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] words [8];

    always #4 clk = ~clk;

    boot_selftest_seq dut (
        .clk(clk), .rst_n(rst_n), .st_done(st_done), .st_pass(st_pass),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .fail_n(fail_n), .init_done(init_done)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sum();
        logic [31:0] s = 32'h0;
        for (int i = 0; i < 8; i++) s = s + words[i];
        return s;
    endfunction

    task automatic fill(input bit zero_sum);
        logic [31:0] s = 32'h0;
        for (int i = 0; i < 8; i++) begin
            words[i] = $urandom;
            if (i < 7) s = s + words[i];
        end
        if (zero_sum) words[7] = 32'h0 - s;
    endtask

    task automatic do_reset();
        rst_n = 0; st_done = 0; st_pass = 0; mem_rvalid = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        chk(fail_n == 0 && mem_req == 0 && init_done == 0, "R1", "in reset",
            {29'd0, fail_n, mem_req, init_done}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(fail_n == 0 && mem_req == 0 && init_done == 0, "R1", "after release",
            {29'd0, fail_n, mem_req, init_done}, 32'h0);
    endtask

    // abort_at >= 0 asserts reset just before that word's data
    task automatic run_boot(input bit pass_st, input int st_cycles,
                            input bit stray, input int abort_at);
        logic [31:0] s;
        for (int i = 0; i < st_cycles; i++) begin
            mem_rvalid = (stray && i == 0);
            mem_rdata  = 32'h1234_5678;
            @(negedge clk);
            chk(fail_n == 0 && mem_req == 0, "R2", "self-test phase",
                {30'd0, fail_n, mem_req}, 32'h0);
        end
        mem_rvalid = 0;
        st_done = 1; st_pass = pass_st;
        @(negedge clk);
        if (!pass_st) begin
            for (int i = 0; i < 12; i++) begin
                chk(fail_n == 0 && mem_req == 0 && init_done == 0, "R4",
                    "self-test failure sticky", {29'd0, fail_n, mem_req, init_done}, 32'h0);
                @(negedge clk);
            end
            return;
        end
        chk(fail_n == 1, "R3", "fail_n released", {31'd0, fail_n}, 32'h1);
        for (int w = 0; w < 8; w++) begin
            int d;
            if (w > 0) begin
                @(negedge clk);
                mem_rvalid = 0;
            end
            if (w == abort_at) begin
                rst_n = 0;
                #1;
                chk(fail_n == 0 && mem_req == 0, "R9", "reset mid-read",
                    {30'd0, fail_n, mem_req}, 32'h0);
                return;
            end
            chk(mem_req == 1 && mem_addr == 32'(w * 4), w == 0 ? "R3" : "R5",
                "request address", mem_addr, 32'(w * 4));
            if (stray) begin
                mem_rvalid = 1; mem_rdata = 32'hDEAD_0001;
            end
            @(negedge clk);
            mem_rvalid = 0;
            d = int'($urandom % 4);
            for (int k = 0; k < d; k++) begin
                chk(mem_req == 0, "R5", "no request while waiting", {31'd0, mem_req}, 32'h0);
                @(negedge clk);
            end
            chk(mem_req == 0, "R5", "no request before valid", {31'd0, mem_req}, 32'h0);
            mem_rvalid = 1; mem_rdata = words[w];
        end
        @(negedge clk);
        mem_rvalid = 0;
        s = exp_sum();
        if (s == 0)
            chk(init_done == 1 && fail_n == 1, "R7", "zero sum verdict",
                {30'd0, init_done, fail_n}, 32'h3);
        else
            chk(init_done == 0 && fail_n == 0, "R8", "nonzero sum verdict",
                {30'd0, init_done, fail_n}, 32'h0);
        for (int i = 0; i < 6; i++) begin
            mem_rvalid = stray; mem_rdata = 32'h0BAD_F00D;
            @(negedge clk);
            chk(init_done == 0 && mem_req == 0 && fail_n == (s == 0),
                (s == 0) ? (stray ? "R6" : "R7") : "R8", "after verdict",
                {29'd0, init_done, mem_req, fail_n}, {31'd0, s == 0});
        end
        mem_rvalid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // directed: all zero passes R7
        for (int i = 0; i < 8; i++) words[i] = 0;
        do_reset(); run_boot(1, 3, 0, -1);
        // directed: carry discarded R7
        words[0] = 32'hFFFF_FFFF; words[5] = 32'h1;
        do_reset(); run_boot(1, 2, 0, -1);
        // directed: sum of one fails R8
        for (int i = 0; i < 8; i++) words[i] = 0;
        words[7] = 32'h1;
        do_reset(); run_boot(1, 1, 0, -1);
        // directed: self-test failure R4
        do_reset(); run_boot(0, 4, 0, -1);
        // stray valids on a zero-sum set R6
        fill(1);
        do_reset(); run_boot(1, 3, 1, -1);
        // reset mid-read then clean restart R9
        fill(1);
        do_reset(); run_boot(1, 2, 0, 3);
        do_reset(); run_boot(1, 2, 0, -1);
        // constrained random runs
        for (int r = 0; r < 12; r++) begin
            fill(r % 2 == 0);
            do_reset();
            run_boot(($urandom % 6) != 0, 1 + int'($urandom % 5), ($urandom % 3) == 0, -1);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule